// File: doc/BRIEF.md
# Hit-Filtered Line Buffer in Front of a Level-1 Cache

This block places a small direct-mapped line buffer between a processor and its level-1 cache. Its aim is fewer level-1 accesses and so less energy. Every processor read looks in the buffer first. When the buffer holds the line, the word comes back on the next cycle and the level-1 port stays idle. When the buffer misses, the read goes to the level-1 cache. If the level-1 cache holds the line, the word is returned and the whole line is copied into the buffer. If the level-1 cache misses, the level-1 cache refills itself from the next memory level and answers the read, but the buffer takes no copy. A line that is used only once therefore never displaces a useful buffer entry.

Processor writes do not allocate in the buffer. A write removes any buffer copy of its line and passes on to the level-1 cache, so the buffer never holds stale data. A synchronous flush input empties the buffer. Three event counters report buffer hits, level-1 accesses and level-1 read misses. Only one processor request is in flight at any time.

The controller has three states. IDLE accepts a request. HIT_RSP presents a buffer hit for one cycle. L1_WAIT holds a level-1 request until the acknowledge arrives. The transitions are:
- IDLE to HIT_RSP when a read is accepted and hits in the buffer.
- IDLE to L1_WAIT when a read that misses in the buffer, or any write, is accepted.
- HIT_RSP to IDLE unconditionally.
- L1_WAIT to IDLE on the level-1 acknowledge.
- IDLE to IDLE when no request is offered.

Top module: `hitbuf_cache`

## Requirements
- R1: After reset no buffer line is valid, all three counters read zero, `cpu_req_ready` is high, and `cpu_rsp_valid` and `l1_req_valid` are low.
- R2: A read accepted at clock edge k that hits in the buffer raises `cpu_rsp_valid` with the stored word in the cycle after edge k. During that transaction `l1_req_valid` is never asserted, and `cnt_buf_hit` increments by one.
- R3: A read that misses in the buffer drives `l1_req_valid` with the captured word address. The response is given in the same cycle as the level-1 acknowledge, using the word picked by the offset. When `l1_rsp_hit` is 1, the full line is written into the buffer, so a later read to that line is a buffer hit.
- R4: When the acknowledge of a read carries `l1_rsp_hit` = 0, the processor still gets the word from `l1_rsp_line`, but the buffer is left unchanged, so the next read to that line goes to level 1 again. `cnt_l1_miss` increments by one.
- R5: A write (`cpu_req_we` = 1) drives `l1_req_valid` with `l1_req_we` = 1 and the write data, and is answered in the acknowledge cycle. It clears any valid buffer line with the same index and tag, so a following read of that line goes to level 1 and returns the new data.
- R6: A cycle with `flush` high clears every valid bit. A read after a flush misses in the buffer, and flush takes priority over a fill in the same cycle.
- R7: `cpu_req_ready` is high only when no transaction is in flight, and is low whenever `cpu_rsp_valid` is high. `l1_req_valid`, `l1_req_addr` and `l1_req_we` stay constant from the time they are raised until the acknowledge.
- R8: `cpu_req_addr` is a word address. Bits [1:0] pick the word in a 4-word line, bits [4:2] pick one of 8 buffer lines, and bits [15:5] form the tag. Word w of `l1_rsp_line` sits at bits [32w+31:32w]. Two lines with the same index and different tags evict each other.
- R9: `cnt_l1_access` increments once for every level-1 request (each buffer read miss and each write). All counters wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Synchronous invalidate of all buffer lines |
| cpu_req_valid | input | 1 | Processor request offered |
| cpu_req_ready | output | 1 | Request accepted when high together with valid |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 16 | Word address |
| cpu_req_wdata | input | 32 | Write data |
| cpu_rsp_valid | output | 1 | Response strobe, one cycle |
| cpu_rsp_rdata | output | 32 | Read data |
| l1_req_valid | output | 1 | Level-1 request, held until acknowledge |
| l1_req_we | output | 1 | Level-1 write |
| l1_req_addr | output | 16 | Level-1 word address |
| l1_req_wdata | output | 32 | Level-1 write data |
| l1_rsp_valid | input | 1 | Level-1 acknowledge |
| l1_rsp_hit | input | 1 | Line was present in level 1 before this access |
| l1_rsp_line | input | 128 | Full line containing the requested word |
| cnt_buf_hit | output | 16 | Buffer hit count |
| cnt_l1_access | output | 16 | Level-1 request count |
| cnt_l1_miss | output | 16 | Level-1 read miss count |

## Verification
The bench reads a line twice straight after a level-1 miss. A design that allocated on a miss would answer the second read fast, without touching level 1. It places two lines on the same index and checks that each evicts the other, which catches an index or tag field taken from the wrong bits. It writes to a line that sits in the buffer and then reads it back, which exposes a design that keeps the stale copy or skips the pass-through. It reads a buffered line after a flush, and it checks the hit latency and the three counters, so a slow hit path, a level-1 request issued on a buffer hit, or a miscounted event all show up as failures.

// File: rtl/hitbuf_pkg.sv
package hitbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HIT_RSP = 2'd1,
        ST_L1_WAIT = 2'd2
    } hb_state_e;
endpackage

// File: rtl/hitbuf_counter.sv
module hitbuf_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   value <= '0;
        else if (inc) value <= value + 1'b1;
    end
endmodule

// File: rtl/hitbuf_store.sv
module hitbuf_store #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int LINES      = 8,
    localparam int OFF_W  = $clog2(LINE_WORDS),
    localparam int IDX_W  = $clog2(LINES),
    localparam int LA_W   = ADDR_W - OFF_W,
    localparam int TAG_W  = LA_W - IDX_W,
    localparam int LINE_W = DATA_W * LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_word,
    input  logic              fill_en,
    input  logic [LA_W-1:0]   fill_la,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              inv_en,
    input  logic [LA_W-1:0]   inv_la
);
    logic [LINES-1:0] v_vec;
    logic [TAG_W-1:0]  t_arr [LINES];
    logic [LINE_W-1:0] d_arr [LINES];

    logic [IDX_W-1:0] fill_idx, inv_idx, lk_idx;
    logic [TAG_W-1:0] fill_tag, inv_tag, lk_tag;
    logic [OFF_W-1:0] lk_off;

    assign fill_idx = fill_la[IDX_W-1:0];
    assign fill_tag = fill_la[LA_W-1:IDX_W];
    assign inv_idx  = inv_la[IDX_W-1:0];
    assign inv_tag  = inv_la[LA_W-1:IDX_W];
    assign lk_off   = lk_addr[OFF_W-1:0];
    assign lk_idx   = lk_addr[OFF_W +: IDX_W];
    assign lk_tag   = lk_addr[ADDR_W-1 -: TAG_W];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic              v_q;
        logic [TAG_W-1:0]  t_q;
        logic [LINE_W-1:0] d_q;
        logic              fill_here, inv_here;

        assign fill_here = fill_en && (fill_idx == IDX_W'(g));
        assign inv_here  = inv_en && (inv_idx == IDX_W'(g)) && v_q && (t_q == inv_tag);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         v_q <= 1'b0;
            else if (flush)     v_q <= 1'b0;
            else if (fill_here) v_q <= 1'b1;
            else if (inv_here)  v_q <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (fill_here) begin
                t_q <= fill_tag;
                d_q <= fill_line;
            end
        end

        assign v_vec[g] = v_q;
        assign t_arr[g] = t_q;
        assign d_arr[g] = d_q;
    end

    always_comb begin
        lk_hit  = v_vec[lk_idx] && (t_arr[lk_idx] == lk_tag);
        lk_word = d_arr[lk_idx][int'(lk_off)*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/hitbuf_ctrl.sv
module hitbuf_ctrl
    import hitbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      req_we,
    input  logic      lookup_hit,
    input  logic      l1_ack,
    output hb_state_e state,
    output logic      req_ready,
    output logic      accept_hit,
    output logic      accept_l1,
    output logic      l1_done
);
    hb_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept_hit)     state_nx = ST_HIT_RSP;
                else if (accept_l1) state_nx = ST_L1_WAIT;
            end
            ST_HIT_RSP: state_nx = ST_IDLE;
            ST_L1_WAIT: if (l1_ack) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready  = (state == ST_IDLE);
        accept_hit = req_ready && req_valid && !req_we && lookup_hit;
        accept_l1  = req_ready && req_valid && (req_we || !lookup_hit);
        l1_done    = (state == ST_L1_WAIT) && l1_ack;
    end
endmodule

// File: rtl/hitbuf_cache.sv
module hitbuf_cache
    import hitbuf_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int LINES      = 8,
    parameter int CNT_W      = 16,
    localparam int OFF_W  = $clog2(LINE_WORDS),
    localparam int LINE_W = DATA_W * LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              l1_req_valid,
    output logic              l1_req_we,
    output logic [ADDR_W-1:0] l1_req_addr,
    output logic [DATA_W-1:0] l1_req_wdata,
    input  logic              l1_rsp_valid,
    input  logic              l1_rsp_hit,
    input  logic [LINE_W-1:0] l1_rsp_line,
    output logic [CNT_W-1:0]  cnt_buf_hit,
    output logic [CNT_W-1:0]  cnt_l1_access,
    output logic [CNT_W-1:0]  cnt_l1_miss
);
    localparam int N_CNT = 3;

    hb_state_e         state;
    logic              accept_hit, accept_l1, l1_done;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_word;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] hit_word_q;
    logic              fill_en;
    logic [N_CNT-1:0]  cnt_inc;
    logic [CNT_W-1:0]  cnt_val [N_CNT];

    hitbuf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (cpu_req_valid),
        .req_we     (cpu_req_we),
        .lookup_hit (lk_hit),
        .l1_ack     (l1_rsp_valid),
        .state      (state),
        .req_ready  (cpu_req_ready),
        .accept_hit (accept_hit),
        .accept_l1  (accept_l1),
        .l1_done    (l1_done)
    );

    hitbuf_store #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .LINE_WORDS (LINE_WORDS),
        .LINES      (LINES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_addr   (cpu_req_addr),
        .lk_hit    (lk_hit),
        .lk_word   (lk_word),
        .fill_en   (fill_en),
        .fill_la   (addr_q[ADDR_W-1:OFF_W]),
        .fill_line (l1_rsp_line),
        .inv_en    (accept_l1 && cpu_req_we),
        .inv_la    (cpu_req_addr[ADDR_W-1:OFF_W])
    );

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            we_q       <= 1'b0;
            wdata_q    <= '0;
            hit_word_q <= '0;
        end else begin
            if (accept_hit || accept_l1) begin
                addr_q  <= cpu_req_addr;
                we_q    <= cpu_req_we;
                wdata_q <= cpu_req_wdata;
            end
            if (accept_hit) hit_word_q <= lk_word;
        end
    end

    always_comb begin
        fill_en       = l1_done && !we_q && l1_rsp_hit;
        l1_req_valid  = (state == ST_L1_WAIT);
        l1_req_we     = we_q;
        l1_req_addr   = addr_q;
        l1_req_wdata  = wdata_q;
        cpu_rsp_valid = (state == ST_HIT_RSP) || l1_done;
        cpu_rsp_rdata = (state == ST_HIT_RSP) ? hit_word_q
                      : l1_rsp_line[int'(addr_q[OFF_W-1:0])*DATA_W +: DATA_W];
        cnt_inc       = {l1_done && !we_q && !l1_rsp_hit, accept_l1, accept_hit};
    end

    for (genvar c = 0; c < N_CNT; c++) begin : g_cnt
        hitbuf_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[c]),
            .value (cnt_val[c])
        );
    end

    assign cnt_buf_hit   = cnt_val[0];
    assign cnt_l1_access = cnt_val[1];
    assign cnt_l1_miss   = cnt_val[2];
endmodule

// File: rtl/hitbuf_checker.sv
module hitbuf_checker #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_req_we,
    input logic              cpu_rsp_valid,
    input logic              l1_req_valid,
    input logic              l1_req_we,
    input logic [ADDR_W-1:0] l1_req_addr,
    input logic              l1_rsp_valid,
    input logic              lk_hit,
    input logic [CNT_W-1:0]  cnt_l1_access
);
    p_hit_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready && !cpu_req_we && lk_hit)
        |=> (cpu_rsp_valid && !l1_req_valid));

    p_write_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready && cpu_req_we)
        |=> (l1_req_valid && l1_req_we));

    p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    p_single_txn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |-> !cpu_req_ready);

    p_l1_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_req_valid && !l1_rsp_valid)
        |=> (l1_req_valid && $stable(l1_req_addr) && $stable(l1_req_we)));

    p_l1_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready && (cpu_req_we || !lk_hit))
        |=> (cnt_l1_access == CNT_W'($past(cnt_l1_access) + 1'b1)));
endmodule

bind hitbuf_cache hitbuf_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_req_we    (cpu_req_we),
    .cpu_rsp_valid (cpu_rsp_valid),
    .l1_req_valid  (l1_req_valid),
    .l1_req_we     (l1_req_we),
    .l1_req_addr   (l1_req_addr),
    .l1_rsp_valid  (l1_rsp_valid),
    .lk_hit        (lk_hit),
    .cnt_l1_access (cnt_l1_access)
);

// File: tb/test_hitbuf_cache.sv
`timescale 1ns/1ps
module test_hitbuf_cache;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int LW     = 4;
    localparam int CNT_W  = 16;
    localparam int LINE_W = DATA_W * LW;
    localparam int L1_LAT = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic              cpu_req_valid = 1'b0;
    logic              cpu_req_ready;
    logic              cpu_req_we = 1'b0;
    logic [ADDR_W-1:0] cpu_req_addr = '0;
    logic [DATA_W-1:0] cpu_req_wdata = '0;
    logic              cpu_rsp_valid;
    logic [DATA_W-1:0] cpu_rsp_rdata;
    logic              l1_req_valid, l1_req_we;
    logic [ADDR_W-1:0] l1_req_addr;
    logic [DATA_W-1:0] l1_req_wdata;
    logic              l1_rsp_valid = 1'b0;
    logic              l1_rsp_hit = 1'b0;
    logic [LINE_W-1:0] l1_rsp_line = '0;
    logic [CNT_W-1:0]  cnt_buf_hit, cnt_l1_access, cnt_l1_miss;

    hitbuf_cache i_hitbuf_cache (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
        .l1_req_valid(l1_req_valid), .l1_req_we(l1_req_we), .l1_req_addr(l1_req_addr),
        .l1_req_wdata(l1_req_wdata), .l1_rsp_valid(l1_rsp_valid), .l1_rsp_hit(l1_rsp_hit),
        .l1_rsp_line(l1_rsp_line), .cnt_buf_hit(cnt_buf_hit),
        .cnt_l1_access(cnt_l1_access), .cnt_l1_miss(cnt_l1_miss)
    );

    always #2 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [DATA_W-1:0] data;
        bit                is_wr;
        bit                via_l1;
        int                acc_cyc;
        string             req;
    } exp_t;
    exp_t sb[$];

    bit                l1_seen = 1'b0;
    int                exp_fast = 0, exp_l1 = 0, tb_misses = 0;
    bit                l1_res[int];
    logic [DATA_W-1:0] wmem[int];

    function automatic logic [DATA_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        if (wmem.exists(int'(a))) return wmem[int'(a)];
        return {a ^ 16'h5A3C, a};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // level-1 cache plus backing memory model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && l1_req_valid) begin
                logic [ADDR_W-1:0] a;
                logic              w;
                logic [DATA_W-1:0] wd;
                bit                h;
                int                la;
                a = l1_req_addr; w = l1_req_we; wd = l1_req_wdata;
                for (int k = 0; k < L1_LAT; k++) begin
                    @(negedge clk);
                    check(l1_req_valid && l1_req_addr == a && l1_req_we == w,
                          "R7", "level-1 request held", {47'd0, l1_req_addr, l1_req_valid}, {47'd0, a, 1'b1});
                end
                la = int'(a) >> 2;
                if (w) begin
                    wmem[int'(a)] = wd;
                    h = 1'b1;
                end else begin
                    h = l1_res.exists(la);
                    if (!h) begin
                        l1_res[la] = 1'b1;
                        tb_misses++;
                    end
                end
                for (int wi = 0; wi < LW; wi++)
                    l1_rsp_line[wi*DATA_W +: DATA_W] = word_of(ADDR_W'((la << 2) + wi));
                l1_rsp_hit   = h;
                l1_seen      = 1'b1;
                l1_rsp_valid = 1'b1;
                @(negedge clk);
                l1_rsp_valid = 1'b0;
            end
        end
    end

    // monitor: compares responses against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && cpu_rsp_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R7", "unexpected response", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(!cpu_req_ready, "R7", "ready low during response", 64'(cpu_req_ready), 64'd0);
                    check(l1_seen == e.via_l1, e.req, "level-1 used", 64'(l1_seen), 64'(e.via_l1));
                    if (!e.is_wr)
                        check(cpu_rsp_rdata == e.data, e.req, "read data", 64'(cpu_rsp_rdata), 64'(e.data));
                    if (!e.via_l1)
                        check(cyc == e.acc_cyc + 1, "R2", "hit latency", 64'(cyc - e.acc_cyc), 64'd1);
                end
                l1_seen = 1'b0;
            end
        end
    end

    task automatic xfer(input logic [ADDR_W-1:0] a, input bit we, input logic [DATA_W-1:0] wd,
                        input bit via_l1, input string req);
        exp_t e;
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = wd;
        while (!cpu_req_ready) @(negedge clk);
        e.data = we ? wd : word_of(a);
        e.is_wr = we; e.via_l1 = via_l1; e.acc_cyc = cyc; e.req = req;
        sb.push_back(e);
        if (via_l1) exp_l1++; else exp_fast++;
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input bit via_l1, input string req);
        xfer(a, 1'b0, '0, via_l1, req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cpu_req_ready == 1'b1, "R1", "ready after reset", 64'(cpu_req_ready), 64'd1);
        check(!cpu_rsp_valid && !l1_req_valid, "R1", "idle outputs", {62'd0, cpu_rsp_valid, l1_req_valid}, 64'd0);
        check(cnt_buf_hit == 0 && cnt_l1_access == 0 && cnt_l1_miss == 0, "R1", "counters zero",
              {16'd0, cnt_buf_hit, cnt_l1_access, cnt_l1_miss}, 64'd0);

        // R4: level-1 miss serves data but does not fill the buffer
        rd(16'h0123, 1'b1, "R4");
        check(cnt_l1_miss == 1, "R4", "miss counter", 64'(cnt_l1_miss), 64'd1);
        rd(16'h0123, 1'b1, "R4");          // still via L1: no allocation on miss
        // R3: that access hit in L1, so the line is now buffered
        rd(16'h0121, 1'b0, "R3");
        rd(16'h0120, 1'b0, "R8");          // other offset, same line
        // R8: conflicting tag on index 0 evicts
        l1_res[16'h0222 >> 2] = 1'b1;
        rd(16'h0222, 1'b1, "R3");
        rd(16'h0223, 1'b0, "R8");
        rd(16'h0121, 1'b1, "R8");          // evicted, refilled from L1 hit
        rd(16'h0122, 1'b0, "R2");
        // R5: write invalidates the buffered line and passes through
        xfer(16'h0121, 1'b1, 32'hDEAD_BEEF, 1'b1, "R5");
        rd(16'h0121, 1'b1, "R5");
        rd(16'h0121, 1'b0, "R5");
        // R6: flush empties the buffer
        rd(16'h0122, 1'b0, "R6");
        @(negedge clk) flush = 1'b1;
        @(negedge clk) flush = 1'b0;
        rd(16'h0122, 1'b1, "R6");
        rd(16'h0122, 1'b0, "R6");
        // R2/R8: fill every index, then hit each
        for (int i = 0; i < 8; i++) begin
            l1_res[(16'h1000 + i*4) >> 2] = 1'b1;
            rd(ADDR_W'(16'h1000 + i*4 + 1), 1'b1, "R8");
        end
        for (int i = 0; i < 8; i++) rd(ADDR_W'(16'h1000 + i*4 + 3), 1'b0, "R2");

        // R9 / R2 / R4 counters
        repeat (2) @(negedge clk);
        check(cnt_l1_access == CNT_W'(exp_l1), "R9", "level-1 access count", 64'(cnt_l1_access), 64'(exp_l1));
        check(cnt_buf_hit == CNT_W'(exp_fast), "R2", "buffer hit count", 64'(cnt_buf_hit), 64'(exp_fast));
        check(cnt_l1_miss == CNT_W'(tb_misses), "R4", "level-1 miss count", 64'(cnt_l1_miss), 64'(tb_misses));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule